// File: doc/BRIEF.md
# SAR Converter Conversion Sequencer

This block is the digital control core of a successive-approximation converter. A falling edge on the active-low convert-start input launches a conversion. A busy flag is then held high for a fixed number of clock cycles, and nothing except a reset can cut that window short. When the window closes, the result on the sample input is captured into the output register. The output shows the new value in the same cycle that busy drops.

If convert-start is still low when busy drops, the sequencer times an acquisition phase itself and then starts the next conversion. This gives back-to-back conversions for as long as the input stays low. A power-down input blocks new starts. When it arrives during a conversion it only takes effect once that conversion ends. Chip-select and read control only an output-enable that models the tristate data bus. They never affect when conversions start or finish.

Top module: `sar_conv_seq`

## Requirements
- R1: When convert-start is low at a clock edge where it was high at the previous edge, and the block is idle and not powered down, busy is high from that edge on.
- R2: Busy stays high for exactly CONV_CYCLES (default 32) clock cycles. A new convert-start edge or a power-down pulse during that window neither shortens it nor restarts it.
- R3: Conversions start and complete identically whatever the levels of chip-select and read.
- R4: If convert-start is low at the edge where busy falls, and at every edge after it, busy goes high again ACQ_CYCLES (default 8) cycles after it fell. The conversion period is then CONV_CYCLES + ACQ_CYCLES.
- R5: After reset, a convert-start that is held low through reset starts nothing. A conversion begins only once convert-start has been high and then goes low.
- R6: While busy is high, the data output keeps the previous result. At the edge where busy falls, it takes the value present on the sample input at that edge.
- R7: The low-power output is high whenever no conversion is running, including right after each conversion ends. It is low while busy is high.
- R8: The output enable is high only when chip-select and read are both low. The data output value does not depend on either signal.
- R9: A synchronous reset clears busy, zeroes the data output, sets low-power, and ends any conversion in progress.
- R10: While power-down is high, convert-start edges start nothing. If power-down goes high during a conversion, that conversion completes, and no automatic retrigger follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnv_n | input | 1 | Convert-start, active low |
| pwr_dn | input | 1 | Power-down request, active high |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read, active low |
| sample_in | input | W | Result from the converter core, captured at end of conversion |
| busy | output | 1 | High during the conversion window |
| low_pwr | output | 1 | High when no conversion is running |
| data_out | output | W | Last completed result |
| data_oe | output | 1 | Data bus drive enable (low means tristate) |

## Verification
Two things can fall in the same cycle: the end of a conversion and a fresh low on convert-start. This happens when the input is released during a conversion and pulled low again in its final cycle. The bench provokes it by raising convert-start just after the start edge and lowering it exactly one cycle before busy drops. That new edge must not extend the running conversion. Busy must still fall on schedule, and the sequencer must treat the low level as a hold, starting the next conversion after exactly the acquisition time.

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 32,
  parameter int ACQ_CYCLES  = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnv_n,
  input  logic         pwr_dn,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic [W-1:0] sample_in,
  output logic         busy,
  output logic         low_pwr,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  localparam int MAXC = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_ACQ} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          cnv_prev;
  logic [W-1:0]  res;
  logic          lp_q;

  wire start_edge = cnv_prev & ~cnv_n;
  wire conv_last  = (cnt == CW'(CONV_CYCLES - 1));
  wire acq_last   = (cnt == CW'(ACQ_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cnv_prev <= 1'b0;
      res      <= '0;
      lp_q     <= 1'b1;
    end else begin
      cnv_prev <= cnv_n;
      case (st)
        S_IDLE: begin
          if (start_edge && !pwr_dn) begin
            st   <= S_CONV;
            cnt  <= '0;
            lp_q <= 1'b0;
          end
        end
        S_CONV: begin
          if (conv_last) begin
            res  <= sample_in;
            lp_q <= 1'b1;
            cnt  <= '0;
            st   <= (!cnv_n && !pwr_dn) ? S_ACQ : S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ACQ: begin
          if (cnv_n || pwr_dn) begin
            st <= S_IDLE;
          end else if (acq_last) begin
            st   <= S_CONV;
            cnt  <= '0;
            lp_q <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st == S_CONV);
  assign low_pwr  = lp_q;
  assign data_out = res;
  assign data_oe  = ~cs_n & ~rd_n;
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         cnv_n,
  input logic         pwr_dn,
  input logic         busy,
  input logic         low_pwr,
  input logic [W-1:0] data_out
);
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  AST_START_ON_LOW:  assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !$past(cnv_n)); // R1
  AST_BUSY_WIDTH:    assert property (@(posedge clk) disable iff (rst) ($fell(busy) && !$past(rst)) |-> bcnt == CONV_CYCLES); // R2
  AST_BUSY_MAX:      assert property (@(posedge clk) disable iff (rst) bcnt <= CONV_CYCLES); // R2
  AST_DATA_HELD:     assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(data_out)); // R6
  AST_LOWPWR_BUSY:   assert property (@(posedge clk) disable iff (rst) busy |-> !low_pwr); // R7
  AST_PD_BLOCKS:     assert property (@(posedge clk) disable iff (rst) (!busy && pwr_dn) |=> !busy); // R10
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.W(W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cnv_n(cnv_n), .pwr_dn(pwr_dn),
  .busy(busy), .low_pwr(low_pwr), .data_out(data_out)
);

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
  localparam int W = 16;
  localparam int C = 32;
  localparam int A = 8;

  logic clk = 0, rst = 1, cnv_n = 1, pwr_dn = 0, cs_n = 1, rd_n = 1;
  logic [W-1:0] sample_in = '0;
  logic busy, low_pwr, data_oe;
  logic [W-1:0] data_out;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  sar_conv_seq #(.W(W), .CONV_CYCLES(C), .ACQ_CYCLES(A)) u0 (
    .clk(clk), .rst(rst), .cnv_n(cnv_n), .pwr_dn(pwr_dn), .cs_n(cs_n), .rd_n(rd_n),
    .sample_in(sample_in), .busy(busy), .low_pwr(low_pwr),
    .data_out(data_out), .data_oe(data_oe)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1; cnv_n = 1; pwr_dn = 0; cs_n = 1; rd_n = 1;
    tick(3);
    rst = 0;
    tick(1);
    chk("R9 busy after reset", busy, 0);
    chk("R9 data after reset", data_out, 0);
    chk("R9 low_pwr after reset", low_pwr, 1);
    chk("R8 oe deselected", data_oe, 0);
  endtask

  task automatic t_single(logic [W-1:0] v, logic [W-1:0] prev);
    cs_n = 1; rd_n = 1;
    sample_in = v;
    cnv_n = 0;
    tick(1);
    chk("R1 busy on fall", busy, 1);
    chk("R3 start with cs/rd high", busy, 1);
    chk("R7 low_pwr low in conversion", low_pwr, 0);
    cnv_n = 1;
    tick(C - 1);
    chk("R2 busy last cycle", busy, 1);
    chk("R6 previous data during conversion", data_out, prev);
    chk("R8 oe low while deselected", data_oe, 0);
    tick(1);
    chk("R2 busy falls after window", busy, 0);
    chk("R6 new data at busy fall", data_out, v);
    chk("R7 low_pwr at end", low_pwr, 1);
    tick(2);
  endtask

  task automatic t_noabort(logic [W-1:0] v, logic [W-1:0] prev);
    cs_n = 0; rd_n = 0;
    sample_in = v;
    cnv_n = 0;
    tick(1);
    chk("R3 start with cs/rd low", busy, 1);
    cnv_n = 1;
    tick(4);
    cnv_n = 0;
    pwr_dn = 1;
    tick(2);
    cnv_n = 1;
    pwr_dn = 0;
    chk("R2 no abort by pd", busy, 1);
    chk("R8 oe high when selected", data_oe, 1);
    chk("R6 old data on bus", data_out, prev);
    tick(C - 7);
    chk("R2 not restarted, still busy", busy, 1);
    tick(1);
    chk("R2 ends on original schedule", busy, 0);
    chk("R6 result after no-abort", data_out, v);
    tick(2);
  endtask

  task automatic t_retrig(logic [W-1:0] v1, logic [W-1:0] v2);
    sample_in = v1;
    cnv_n = 0;
    tick(1);
    chk("R4 first conversion", busy, 1);
    tick(C);
    chk("R4 busy falls", busy, 0);
    chk("R6 first result", data_out, v1);
    sample_in = v2;
    tick(A - 1);
    chk("R4 still acquiring", busy, 0);
    chk("R7 low_pwr in acquisition", low_pwr, 1);
    tick(1);
    chk("R4 auto retrigger", busy, 1);
    tick(C);
    chk("R4 second end", busy, 0);
    chk("R6 second result", data_out, v2);
    cnv_n = 1;
    tick(A + 2);
    chk("R4 stops when released", busy, 0);
  endtask

  task automatic t_same_cycle();
    cnv_n = 0;
    tick(1);
    cnv_n = 1;
    tick(C - 1);
    chk("R2 busy before late fall", busy, 1);
    cnv_n = 0;
    tick(1);
    chk("R2 late fall does not extend", busy, 0);
    tick(A - 1);
    chk("R4 acquisition after late fall", busy, 0);
    tick(1);
    chk("R4 retrigger after late fall", busy, 1);
    cnv_n = 1;
    tick(C);
    chk("R2 retriggered conversion ends", busy, 0);
    tick(2);
  endtask

  task automatic t_pd();
    pwr_dn = 1;
    tick(1);
    cnv_n = 0;
    tick(3);
    chk("R10 fall ignored in power-down", busy, 0);
    cnv_n = 1;
    pwr_dn = 0;
    tick(1);
    cnv_n = 0;
    tick(1);
    chk("R10 start after power-down", busy, 1);
    pwr_dn = 1;
    tick(C - 1);
    chk("R10 pd deferred", busy, 1);
    tick(1);
    chk("R10 conversion completed", busy, 0);
    tick(A + 2);
    chk("R10 no retrigger in power-down", busy, 0);
    cnv_n = 1;
    pwr_dn = 0;
    tick(2);
  endtask

  task automatic t_reset_mid(logic [W-1:0] v);
    sample_in = v;
    cnv_n = 0;
    tick(1);
    cnv_n = 1;
    tick(5);
    rst = 1;
    tick(1);
    chk("R9 reset ends conversion", busy, 0);
    chk("R9 reset zeroes data", data_out, 0);
    cnv_n = 0;
    tick(2);
    rst = 0;
    tick(4);
    chk("R5 held low after reset starts nothing", busy, 0);
    cnv_n = 1;
    tick(1);
    chk("R5 still idle after high", busy, 0);
    cnv_n = 0;
    tick(1);
    chk("R5 start after fresh fall", busy, 1);
    cnv_n = 1;
    tick(C);
    chk("R6 result after reset", data_out, v);
  endtask

  task automatic t_oe(logic [W-1:0] v);
    cs_n = 0; rd_n = 1; tick(1);
    chk("R8 oe with rd high", data_oe, 0);
    chk("R8 data with rd high", data_out, v);
    cs_n = 1; rd_n = 0; tick(1);
    chk("R8 oe with cs high", data_oe, 0);
    cs_n = 0; rd_n = 0; tick(1);
    chk("R8 oe selected", data_oe, 1);
    chk("R8 data selected", data_out, v);
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    t_reset();
    t_single(16'hA5C3, 16'h0000);
    t_noabort(16'h1234, 16'hA5C3);
    t_retrig(16'hFFFF, 16'h0001);
    t_same_cycle();
    t_pd();
    t_reset_mid(16'h8000);
    t_oe(16'h8000);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule